// File: doc/BRIEF.md
# Subchannel Residual Address Tracker

This block follows the storage address of a cycle-steal disk transfer one word at a time. A transfer is started with a first storage address and the sector ID expected first. Every word moved without error steps the data address register by one. Each sector opens with a boundary strobe, followed by an ID evaluation strobe that carries the sector ID read from the disk and its check-character result. If the ID is bad, the register is wound back to the first word of that sector and the transfer stops. In multisector mode an ID that is out of sequence has the same effect. The fault is reported with a one-cycle channel-end/device-end interrupt and two 16-bit status words: the interrupt status word and its extension.

Recovery code reads the register with a residual-read request to find where the fault happened. That read changes nothing and raises no interrupt. A halt ends the transfer but keeps the register. Only the system reset clears it. A new transfer can only be started when no transfer is active.

Top module: `resid_addr_tracker`

## Requirements
- R1: While `sysRstN` is low, and after it is released, the register is 0, both status words are 0, `xferActive` is 0 and neither interrupt output is high.
- R2: `startXfer` with no active transfer loads the register from `startAddr`, loads the expected ID from `firstId`, latches `multiSector`, clears both status words and sets `xferActive`. While a transfer is active, `startXfer` is ignored.
- R3: `wordDone` during an active transfer adds one to the register, wrapping modulo 2^ADDR_W. `wordDone` has no effect when no transfer is active.
- R4: In the cycle after `residReq`, `residValid` is 1 and `residAddr` holds the register value from the request cycle. The register, the status words and the interrupts are not changed by the request.
- R5: `haltCmd` clears `xferActive` and leaves the register unchanged. It raises no interrupt, and it takes priority over any word or ID strobe in the same cycle.
- R6: An ID evaluation with `idCrcErr` set loads the register with the address the current sector began at. This is the register value at the most recent `sectorStart`, or the present value if `sectorStart` is in the same cycle. It also stops the transfer and sets ISW = 0x1415 and ISWEX = 0x0800. Status bit n is vector index 15-n (bit 0 is the MSB). ISW bits 3, 5, 11, 13 and 15 are set, and ISWEX bit 4 is set.
- R7: In multisector mode, an ID evaluation with a good check character but an ID different from the expected ID rewinds the register in the same way as R6. It stops the transfer and sets ISW = 0x1015 (bits 3, 11, 13, 15) and ISWEX = 0x4000 (bit 1).
- R8: An accepted ID evaluation adds one to the expected ID, wrapping modulo 2^ID_W. In single-sector mode the ID sequence is not checked.
- R9: Each fault drives `chanEndIrq` and `devEndIrq` high together for exactly one cycle, in the cycle after the fault strobe. Nothing else raises them.
- R10: When a single ID evaluation has both a check-character error and an out-of-sequence ID, only the check-character status (R6) is reported.
- R11: The status words keep their values until the next accepted `startXfer` or a reset, including through halts and residual reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | System reset, active low, synchronous |
| startXfer | input | 1 | Start a transfer (one-cycle strobe) |
| startAddr | input | ADDR_W | First storage address of the transfer |
| firstId | input | ID_W | Sector ID expected first |
| multiSector | input | 1 | Multisector mode, latched at start |
| wordDone | input | 1 | One word transferred without error |
| sectorStart | input | 1 | A new sector begins |
| idDone | input | 1 | Sector ID has been read and evaluated |
| sectorId | input | ID_W | Sector ID read from the disk |
| idCrcErr | input | 1 | Check-character error on the sector ID |
| haltCmd | input | 1 | Halt the transfer |
| residReq | input | 1 | Request to read the residual address |
| residAddr | output | ADDR_W | Residual address captured by the last request |
| residValid | output | 1 | `residAddr` updated in this cycle |
| isw | output | 16 | Interrupt status word |
| iswx | output | 16 | Interrupt status word extension |
| xferActive | output | 1 | A transfer is in progress |
| chanEndIrq | output | 1 | Channel-end interrupt pulse |
| devEndIrq | output | 1 | Device-end interrupt pulse |

## Verification
A table of two-sector transfers tries the address tracking with several patterns:
- a clean multisector run, which shows that counting continues across a correct ID;
- a check-character fault after some words were prefetched, which shows that the rewind goes to the sector start and not to the last word;
- an out-of-sequence ID, which selects the other status pattern;
- a wrong ID in single-sector mode, which shows that the sequence check is gated by the mode;
- an ID with both faults, which shows the precedence;
- runs that wrap the address or the ID counter.

Directed tests cover the remaining cases:
- strobes while idle;
- a restart while busy;
- a halt in the middle of a transfer;
- repeated residual reads;
- status that persists until the next start;
- a boundary strobe and a faulty ID in the same cycle.

// File: rtl/resid_pkg.sv
package resid_pkg;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic loadStart;
    logic incAddr;
    logic markSector;
    logic rewind;
    logic setCrc;
    logic setSeq;
    logic bumpId;
  } ctlStrobes_t;

  // Status bit n sits at vector index 15-n (bit 0 is the MSB).
  function automatic logic [15:0] msbBit(input int n);
    return 16'h8000 >> n;
  endfunction

  localparam logic [15:0] ISW_CRC  = msbBit(3) | msbBit(5) | msbBit(11) | msbBit(13) | msbBit(15);
  localparam logic [15:0] ISW_SEQ  = msbBit(3) | msbBit(11) | msbBit(13) | msbBit(15);
  localparam logic [15:0] ISWX_CRC = msbBit(4);
  localparam logic [15:0] ISWX_SEQ = msbBit(1);

endpackage

// File: rtl/resid_ctl.sv
module resid_ctl
  import resid_pkg::*;
(
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        startXfer,
  input  logic        multiSector,
  input  logic        wordDone,
  input  logic        sectorStart,
  input  logic        idDone,
  input  logic        idCrcErr,
  input  logic        idMatch,
  input  logic        haltCmd,
  output ctlStrobes_t strobes,
  output logic        xferActive,
  output logic        irqPulse
);

  logic active;
  logic multiQ;
  logic irqQ;
  logic accept;
  logic crcFault;
  logic seqFault;
  logic anyFault;

  always_comb begin
    accept   = active && !haltCmd;
    crcFault = accept && idDone && idCrcErr;
    seqFault = accept && idDone && !idCrcErr && multiQ && !idMatch;
    anyFault = crcFault || seqFault;

    strobes            = '0;
    strobes.loadStart  = startXfer && !active;
    strobes.incAddr    = accept && wordDone && !anyFault;
    strobes.markSector = accept && sectorStart;
    strobes.rewind     = anyFault;
    strobes.setCrc     = crcFault;
    strobes.setSeq     = seqFault;
    strobes.bumpId     = accept && idDone && !anyFault;
  end

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      active <= 1'b0;
      multiQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      irqQ <= anyFault;
      if (strobes.loadStart) begin
        active <= 1'b1;
        multiQ <= multiSector;
      end else if (haltCmd || anyFault) begin
        active <= 1'b0;
      end
    end
  end

  assign xferActive = active;
  assign irqPulse   = irqQ;

endmodule

// File: rtl/resid_dp.sv
module resid_dp
  import resid_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ID_W-1:0]   firstId,
  input  logic [ID_W-1:0]   sectorId,
  input  logic              sectorStart,
  input  logic              residReq,
  output logic              idMatch,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [ADDR_W-1:0] residAddr,
  output logic              residValid,
  output logic [15:0]       isw,
  output logic [15:0]       iswx
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ID_W-1:0]   ID_ONE   = ID_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] sectorBase;
  logic [ADDR_W-1:0] rewindTarget;
  logic [ID_W-1:0]   expId;

  assign idMatch      = (sectorId == expId);
  assign rewindTarget = sectorStart ? addrQ : sectorBase;

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      addrQ      <= '0;
      sectorBase <= '0;
      expId      <= '0;
      isw        <= '0;
      iswx       <= '0;
      residAddr  <= '0;
      residValid <= 1'b0;
    end else begin
      residValid <= residReq;
      if (residReq) residAddr <= addrQ;

      if (strobes.loadStart) begin
        addrQ      <= startAddr;
        sectorBase <= startAddr;
        expId      <= firstId;
        isw        <= '0;
        iswx       <= '0;
      end else begin
        if (strobes.markSector) sectorBase <= addrQ;
        if (strobes.rewind)       addrQ <= rewindTarget;
        else if (strobes.incAddr) addrQ <= addrQ + ADDR_ONE;
        if (strobes.bumpId) expId <= expId + ID_ONE;
        if (strobes.setCrc) begin
          isw  <= ISW_CRC;
          iswx <= ISWX_CRC;
        end else if (strobes.setSeq) begin
          isw  <= ISW_SEQ;
          iswx <= ISWX_SEQ;
        end
      end
    end
  end

  assign dataAddr = addrQ;

endmodule

// File: rtl/resid_addr_tracker.sv
module resid_addr_tracker
  import resid_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              startXfer,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ID_W-1:0]   firstId,
  input  logic              multiSector,
  input  logic              wordDone,
  input  logic              sectorStart,
  input  logic              idDone,
  input  logic [ID_W-1:0]   sectorId,
  input  logic              idCrcErr,
  input  logic              haltCmd,
  input  logic              residReq,
  output logic [ADDR_W-1:0] residAddr,
  output logic              residValid,
  output logic [15:0]       isw,
  output logic [15:0]       iswx,
  output logic              xferActive,
  output logic              chanEndIrq,
  output logic              devEndIrq
);

  ctlStrobes_t       strobes;
  logic              idMatch;
  logic              irqPulse;
  logic [ADDR_W-1:0] dataAddr;

  resid_ctl u_ctl (
    .clk         (clk),
    .sysRstN     (sysRstN),
    .startXfer   (startXfer),
    .multiSector (multiSector),
    .wordDone    (wordDone),
    .sectorStart (sectorStart),
    .idDone      (idDone),
    .idCrcErr    (idCrcErr),
    .idMatch     (idMatch),
    .haltCmd     (haltCmd),
    .strobes     (strobes),
    .xferActive  (xferActive),
    .irqPulse    (irqPulse)
  );

  resid_dp #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dp (
    .clk         (clk),
    .sysRstN     (sysRstN),
    .strobes     (strobes),
    .startAddr   (startAddr),
    .firstId     (firstId),
    .sectorId    (sectorId),
    .sectorStart (sectorStart),
    .residReq    (residReq),
    .idMatch     (idMatch),
    .dataAddr    (dataAddr),
    .residAddr   (residAddr),
    .residValid  (residValid),
    .isw         (isw),
    .iswx        (iswx)
  );

  assign chanEndIrq = irqPulse;
  assign devEndIrq  = irqPulse;

endmodule

// File: rtl/resid_addr_tracker_chk.sv
module resid_addr_tracker_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              sysRstN,
  input logic              startXfer,
  input logic              wordDone,
  input logic              idDone,
  input logic              haltCmd,
  input logic              residReq,
  input logic [ADDR_W-1:0] dataAddr,
  input logic [ADDR_W-1:0] residAddr,
  input logic              residValid,
  input logic [15:0]       isw,
  input logic              xferActive,
  input logic              chanEndIrq,
  input logic              devEndIrq
);

  p_idle_reset_r1: assert property (@(posedge clk) !sysRstN |=> (dataAddr == '0 && isw == '0 && !xferActive));

  p_word_inc_r3: assert property (@(posedge clk) disable iff (!sysRstN)
    (xferActive && wordDone && !haltCmd && !idDone) |=> dataAddr == $past(dataAddr) + ADDR_W'(1));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!sysRstN)
    (!xferActive && !startXfer) |=> dataAddr == $past(dataAddr));

  p_resid_value_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    residReq |=> (residValid && residAddr == $past(dataAddr)));

  p_halt_keeps_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    haltCmd |=> (dataAddr == $past(dataAddr) && !xferActive && !chanEndIrq));

  p_irq_pair_r9: assert property (@(posedge clk) disable iff (!sysRstN)
    chanEndIrq == devEndIrq);

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!sysRstN)
    chanEndIrq |=> !chanEndIrq);

  p_irq_status_r9: assert property (@(posedge clk) disable iff (!sysRstN)
    chanEndIrq |-> (isw[12] && isw[4] && isw[2] && isw[0] && !xferActive));

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!sysRstN)
    (!xferActive && !startXfer) |=> isw == $past(isw));

endmodule

bind resid_addr_tracker resid_addr_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .sysRstN    (sysRstN),
  .startXfer  (startXfer),
  .wordDone   (wordDone),
  .idDone     (idDone),
  .haltCmd    (haltCmd),
  .residReq   (residReq),
  .dataAddr   (dataAddr),
  .residAddr  (residAddr),
  .residValid (residValid),
  .isw        (isw),
  .xferActive (xferActive),
  .chanEndIrq (chanEndIrq),
  .devEndIrq  (devEndIrq)
);

// File: tb/test_resid_addr_tracker.sv
module test_resid_addr_tracker;

  localparam int ADDR_W = 16;
  localparam int ID_W   = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              sysRstN = 1'b0;
  logic              startXfer = 1'b0, multiSector = 1'b0, wordDone = 1'b0;
  logic              sectorStart = 1'b0, idDone = 1'b0, idCrcErr = 1'b0;
  logic              haltCmd = 1'b0, residReq = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [ID_W-1:0]   firstId = '0, sectorId = '0;
  logic [ADDR_W-1:0] residAddr;
  logic              residValid, xferActive, chanEndIrq, devEndIrq;
  logic [15:0]       isw, iswx;

  resid_addr_tracker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) i_resid_addr_tracker (
    .clk(clk), .sysRstN(sysRstN), .startXfer(startXfer), .startAddr(startAddr),
    .firstId(firstId), .multiSector(multiSector), .wordDone(wordDone),
    .sectorStart(sectorStart), .idDone(idDone), .sectorId(sectorId),
    .idCrcErr(idCrcErr), .haltCmd(haltCmd), .residReq(residReq),
    .residAddr(residAddr), .residValid(residValid), .isw(isw), .iswx(iswx),
    .xferActive(xferActive), .chanEndIrq(chanEndIrq), .devEndIrq(devEndIrq)
  );

  int nChecks = 0, nFails = 0;
  int chanCnt = 0, devCnt = 0;

  always @(negedge clk) begin
    if (chanEndIrq) chanCnt++;
    if (devEndIrq)  devCnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doStart(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id, input logic m);
    startAddr = a; firstId = id; multiSector = m; startXfer = 1'b1;
    tick(); startXfer = 1'b0;
  endtask

  task automatic doWords(input int n);
    for (int i = 0; i < n; i++) begin
      wordDone = 1'b1; tick(); wordDone = 1'b0;
    end
  endtask

  task automatic doSector();
    sectorStart = 1'b1; tick(); sectorStart = 1'b0;
  endtask

  task automatic doId(input logic [ID_W-1:0] id, input logic err);
    sectorId = id; idCrcErr = err; idDone = 1'b1;
    tick(); idDone = 1'b0; idCrcErr = 1'b0;
  endtask

  task automatic doHalt();
    haltCmd = 1'b1; tick(); haltCmd = 1'b0;
  endtask

  task automatic readResid(output logic [ADDR_W-1:0] a, output logic v);
    residReq = 1'b1; tick(); residReq = 1'b0;
    a = residAddr; v = residValid;
  endtask

  // sAddr, fId, multi, w0, id1, crc1, pre1, expAddr, expIsw, expIswx, expIrq
  typedef struct packed {
    logic [15:0] sAddr;
    logic [7:0]  fId;
    logic        multi;
    logic [3:0]  w0;
    logic [7:0]  id1;
    logic        crc1;
    logic [3:0]  pre1;
    logic [15:0] expAddr;
    logic [15:0] expIsw;
    logic [15:0] expIswx;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0100, 8'h05, 1'b1, 4'd4, 8'h06, 1'b0, 4'd1, 16'h0107, 16'h0000, 16'h0000, 1'b0}, // R3 R8 clean
    '{16'h0200, 8'h05, 1'b1, 4'd3, 8'h06, 1'b1, 4'd2, 16'h0203, 16'h1415, 16'h0800, 1'b1}, // R6 crc
    '{16'h0300, 8'h10, 1'b1, 4'd5, 8'h12, 1'b0, 4'd2, 16'h0305, 16'h1015, 16'h4000, 1'b1}, // R7 seq
    '{16'h0400, 8'h10, 1'b0, 4'd2, 8'h33, 1'b0, 4'd1, 16'h0405, 16'h0000, 16'h0000, 1'b0}, // R8 single
    '{16'h0500, 8'h20, 1'b1, 4'd2, 8'h25, 1'b1, 4'd0, 16'h0502, 16'h1415, 16'h0800, 1'b1}, // R10 both
    '{16'hFFFE, 8'h01, 1'b1, 4'd3, 8'h02, 1'b0, 4'd0, 16'h0003, 16'h0000, 16'h0000, 1'b0}, // R3 wrap
    '{16'h0600, 8'hFF, 1'b1, 4'd1, 8'h00, 1'b0, 4'd1, 16'h0604, 16'h0000, 16'h0000, 1'b0}  // R8 id wrap
  };

  logic [ADDR_W-1:0] ra;
  logic              rv;
  int                c0, d0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 isw", isw, 16'h0);
    check("R1 iswx", iswx, 16'h0);
    check("R1 active", xferActive, 0);
    check("R1 irq", chanEndIrq | devEndIrq, 0);
    sysRstN = 1'b1; tick();
    readResid(ra, rv);
    check("R1 addr", ra, 0);
    check("R4 valid", rv, 1);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      c0 = chanCnt; d0 = devCnt;
      doStart(VECS[k].sAddr, VECS[k].fId, VECS[k].multi);
      doSector(); doId(VECS[k].fId, 1'b0);
      doWords(int'(VECS[k].w0));
      doSector(); doWords(int'(VECS[k].pre1));
      doId(VECS[k].id1, VECS[k].crc1);
      doWords(2);
      doHalt();
      readResid(ra, rv);
      check($sformatf("R6/R7 vec%0d addr", k), ra, VECS[k].expAddr);
      check($sformatf("R6/R7 vec%0d isw", k), isw, VECS[k].expIsw);
      check($sformatf("R6/R7 vec%0d iswx", k), iswx, VECS[k].expIswx);
      check($sformatf("R9 vec%0d chan count", k), chanCnt - c0, int'(VECS[k].expIrq));
      check($sformatf("R9 vec%0d dev count", k), devCnt - d0, int'(VECS[k].expIrq));
    end

    // R3 words ignored while idle
    doWords(3);
    readResid(ra, rv);
    check("R3 idle words ignored", ra, 16'h0604);

    // R2 restart ignored while busy; R4 repeat reads; R5 halt
    c0 = chanCnt;
    doStart(16'h0040, 8'h03, 1'b1);
    check("R2 active", xferActive, 1);
    check("R2 status cleared", isw, 16'h0);
    doStart(16'h0900, 8'h00, 1'b0);
    doWords(2);
    readResid(ra, rv);
    check("R2 restart ignored", ra, 16'h0042);
    readResid(ra, rv);
    check("R4 read repeat", ra, 16'h0042);
    check("R4 no irq", chanCnt - c0, 0);
    check("R4 still active", xferActive, 1);
    haltCmd = 1'b1; wordDone = 1'b1; tick(); haltCmd = 1'b0; wordDone = 1'b0;
    check("R5 inactive", xferActive, 0);
    doWords(2);
    readResid(ra, rv);
    check("R5 addr kept", ra, 16'h0042);
    check("R5 no irq", chanCnt - c0, 0);

    // R11 status persists; R7 seq fault; R9 pulse
    doStart(16'h0700, 8'h09, 1'b1);
    doSector(); doId(8'h09, 1'b0);
    doWords(1);
    doSector();
    sectorId = 8'h0B; idDone = 1'b1; tick(); idDone = 1'b0;
    check("R9 chan pulse", chanEndIrq, 1);
    check("R9 dev pulse", devEndIrq, 1);
    tick();
    check("R9 pulse ends", chanEndIrq, 0);
    repeat (4) tick();
    doHalt();
    readResid(ra, rv);
    check("R7 addr rewound", ra, 16'h0701);
    check("R11 isw persists", isw, 16'h1015);
    check("R11 iswx persists", iswx, 16'h4000);
    doStart(16'h0A00, 8'h01, 1'b1);
    check("R11 cleared by start", isw, 16'h0);

    // R6 boundary and faulty ID in same cycle
    doSector(); doId(8'h01, 1'b0);
    doWords(3);
    sectorStart = 1'b1; idDone = 1'b1; sectorId = 8'h02; idCrcErr = 1'b1;
    tick(); sectorStart = 1'b0; idDone = 1'b0; idCrcErr = 1'b0;
    readResid(ra, rv);
    check("R6 same-cycle addr", ra, 16'h0A03);
    check("R6 same-cycle isw", isw, 16'h1415);

    // R1 reset clears everything
    sysRstN = 1'b0; tick(); sysRstN = 1'b1; tick();
    check("R1 isw after reset", isw, 16'h0);
    readResid(ra, rv);
    check("R1 addr after reset", ra, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule